// File: doc/BRIEF.md
# Page Class Key Protection Checker

This block decides whether a data access to a virtual page may go ahead. Every page carries a 5-bit class key, which is copied from its translation entry. The key selects one of 32 classes. A 64-bit authority register holds a read-disable bit and a write-disable bit for each class. The decision applies at both privilege levels. When an access is refused, the block reports whether the read-disable or the write-disable bit caused the refusal.

Both the privileged side and the user side can write the authority register. A privileged write replaces the whole register. A user write changes only the bit positions that a second register, the user mask, enables, and every other bit keeps its old value. Only privileged code can write the user mask. A user attempt to write it leaves the mask unchanged and raises a privilege-violation flag. Both registers can be read at the ports at all times. Page table walking and any masking above the privileged level belong to other blocks.

Top module: `page_class_gate`

## Requirements
- R1: After reset the authority register and the user mask read as zero, so every class is accessible and a user write to the authority register changes nothing. `respValid`, `respAllow`, `faultCause` and `privFault` are 0.
- R2: For class c, bit 63-2c of the authority register is its write-disable bit and bit 62-2c is its read-disable bit. Class 0 therefore holds bits 63:62 and class 31 holds bits 1:0.
- R3: A read access (`accWrite`=0) is refused exactly when the read-disable bit of its class is set.
- R4: A write access (`accWrite`=1) is refused exactly when the write-disable bit of its class is set. The same rule applies for `accUser`=0 and for `accUser`=1.
- R5: A privileged write to the authority register (`regWrEn`=1, `regSel`=0, `regWrUser`=0) replaces all 64 bits with `regWrData`.
- R6: A user write to the authority register (`regSel`=0, `regWrUser`=1) takes `regWrData` only in the bit positions that are set in the user mask. All other bits keep their previous values.
- R7: A privileged write to the user mask (`regSel`=1) loads `regWrData`. A user write to the user mask changes nothing and sets `privFault` to 1 for one cycle.
- R8: `faultCause` codes are 0 for none, 1 for a refusal by read-disable, 2 for a refusal by write-disable and 3 for a privilege violation. If a refused access and a privilege violation occur in the same cycle, the key code is reported and `privFault` is still 1.
- R9: The result of an access appears one cycle after `accValid`, with `respValid`=1. The result is based on the register contents before any write in that same cycle.
- R10: `authOut` and `umaskOut` show the effect of a write one cycle after the write is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access request is present this cycle |
| accKey | input | 5 | Class key of the accessed page |
| accWrite | input | 1 | 1 for a write access, 0 for a read access |
| accUser | input | 1 | 1 if the access is made in user mode |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Write target: 0 selects the authority register, 1 selects the user mask |
| regWrUser | input | 1 | 1 if the write comes from user mode |
| regWrData | input | 64 | Data to write |
| authOut | output | 64 | Current authority register |
| umaskOut | output | 64 | Current user mask |
| respValid | output | 1 | An access result is present |
| respAllow | output | 1 | The access is allowed |
| faultCause | output | 2 | Fault cause code |
| privFault | output | 1 | A user write to the user mask was rejected |

## Verification
Every result of this block is due one clock edge after its stimulus. The access verdict, the fault cause and the privilege flag come from output registers, and the two register readbacks show their new contents after that same single edge. The bench presents each stimulus between clock edges, waits for exactly one rising edge, and samples a quarter period later. One directed case presents a write and an access in the same cycle. It confirms that the verdict follows the old register contents and that the next access follows the new contents.

// File: rtl/page_class_pkg.sv
package page_class_pkg;
  localparam int NUM_CLASSES = 32;
  localparam int KEY_W       = $clog2(NUM_CLASSES);
  localparam int AUTH_W      = 2 * NUM_CLASSES;

  typedef enum logic [1:0] {
    CAUSE_NONE      = 2'd0,
    CAUSE_KEY_READ  = 2'd1,
    CAUSE_KEY_WRITE = 2'd2,
    CAUSE_PRIV      = 2'd3
  } cause_e;

  typedef struct packed {
    logic authLoadFull;
    logic authLoadMasked;
    logic umaskLoad;
    logic privViol;
  } ctrl_strobes_t;
endpackage

// File: rtl/pcg_ctrl.sv
module pcg_ctrl
  import page_class_pkg::*;
(
  input  logic          regWrEn,
  input  logic          regSel,
  input  logic          regWrUser,
  output ctrl_strobes_t strobes
);
  logic toAuth;
  logic toMask;

  assign toAuth = regWrEn & ~regSel;
  assign toMask = regWrEn & regSel;

  always_comb begin
    strobes = '0;
    strobes.authLoadFull   = toAuth & ~regWrUser;
    strobes.authLoadMasked = toAuth & regWrUser;
    strobes.umaskLoad      = toMask & ~regWrUser;
    strobes.privViol       = toMask & regWrUser;
  end
endmodule

// File: rtl/pcg_datapath.sv
module pcg_datapath
  import page_class_pkg::*;
#(
  parameter int CLASSES = NUM_CLASSES,
  parameter int KW      = $clog2(CLASSES),
  parameter int AW      = 2 * CLASSES
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrl_strobes_t strobes,
  input  logic [AW-1:0] regWrData,
  input  logic          accValid,
  input  logic [KW-1:0] accKey,
  input  logic          accWrite,
  output logic [AW-1:0] authOut,
  output logic [AW-1:0] umaskOut,
  output logic          respValid,
  output logic          respAllow,
  output logic [1:0]    faultCause,
  output logic          privFault
);
  logic [AW-1:0]      authReg;
  logic [AW-1:0]      umaskReg;
  logic [CLASSES-1:0] rdDis;
  logic [CLASSES-1:0] wrDis;
  logic               keyHit;
  logic               denyNow;
  cause_e             nextCause;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      authReg <= '0;
    end else if (strobes.authLoadFull) begin
      authReg <= regWrData;
    end else if (strobes.authLoadMasked) begin
      authReg <= (authReg & ~umaskReg) | (regWrData & umaskReg);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      umaskReg <= '0;
    end else if (strobes.umaskLoad) begin
      umaskReg <= regWrData;
    end
  end

  // class 0 sits in the top pair of bits
  for (genvar c = 0; c < CLASSES; c++) begin : g_class
    assign wrDis[c] = authReg[AW-1-2*c];
    assign rdDis[c] = authReg[AW-2-2*c];
  end

  always_comb begin
    keyHit  = accWrite ? wrDis[accKey] : rdDis[accKey];
    denyNow = accValid & keyHit;
    if (denyNow) begin
      nextCause = accWrite ? CAUSE_KEY_WRITE : CAUSE_KEY_READ;
    end else if (strobes.privViol) begin
      nextCause = CAUSE_PRIV;
    end else begin
      nextCause = CAUSE_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respAllow  <= 1'b0;
      faultCause <= CAUSE_NONE;
      privFault  <= 1'b0;
    end else begin
      respValid  <= accValid;
      respAllow  <= accValid & ~keyHit;
      faultCause <= nextCause;
      privFault  <= strobes.privViol;
    end
  end

  assign authOut  = authReg;
  assign umaskOut = umaskReg;
endmodule

// File: rtl/page_class_gate.sv
module page_class_gate
  import page_class_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [KEY_W-1:0]  accKey,
  input  logic              accWrite,
  input  logic              accUser,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic              regWrUser,
  input  logic [AUTH_W-1:0] regWrData,
  output logic [AUTH_W-1:0] authOut,
  output logic [AUTH_W-1:0] umaskOut,
  output logic              respValid,
  output logic              respAllow,
  output logic [1:0]        faultCause,
  output logic              privFault
);
  ctrl_strobes_t strobes;
  logic          unusedUser;

  // the key check is the same at both privilege levels
  assign unusedUser = accUser;

  pcg_ctrl u_ctrl (
    .regWrEn  (regWrEn),
    .regSel   (regSel),
    .regWrUser(regWrUser),
    .strobes  (strobes)
  );

  pcg_datapath #(
    .CLASSES(NUM_CLASSES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .regWrData (regWrData),
    .accValid  (accValid),
    .accKey    (accKey),
    .accWrite  (accWrite),
    .authOut   (authOut),
    .umaskOut  (umaskOut),
    .respValid (respValid),
    .respAllow (respAllow),
    .faultCause(faultCause),
    .privFault (privFault)
  );
endmodule

// File: rtl/pcg_checker.sv
module pcg_checker
  import page_class_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic [KEY_W-1:0]  accKey,
  input logic              accWrite,
  input logic              accUser,
  input logic              regWrEn,
  input logic              regSel,
  input logic              regWrUser,
  input logic [AUTH_W-1:0] regWrData,
  input logic [AUTH_W-1:0] authOut,
  input logic [AUTH_W-1:0] umaskOut,
  input logic              respValid,
  input logic              respAllow,
  input logic [1:0]        faultCause,
  input logic              privFault
);
  // R5
  priv_auth_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regSel && !regWrUser) |=> (authOut == $past(regWrData)));

  // R6
  user_auth_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regSel && regWrUser) |=>
      (((authOut ^ $past(authOut)) & ~$past(umaskOut)) == '0));

  // R7
  user_mask_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel && regWrUser) |=> ($stable(umaskOut) && privFault));

  // R9
  resp_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> respValid);

  // R8
  deny_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respAllow) |->
      (faultCause == CAUSE_KEY_READ || faultCause == CAUSE_KEY_WRITE));

  // R8
  allow_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    respAllow |-> (respValid && faultCause != CAUSE_KEY_READ &&
                   faultCause != CAUSE_KEY_WRITE));

  // R1
  idle_no_verdict_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> !respValid && !respAllow);
endmodule

bind page_class_gate pcg_checker u_pcg_checker (.*);

// File: tb/test_page_class_gate.sv
module test_page_class_gate;
  import page_class_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [4:0]  accKey = '0;
  logic        accWrite = 1'b0;
  logic        accUser = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic        regWrUser = 1'b0;
  logic [63:0] regWrData = '0;
  logic [63:0] authOut;
  logic [63:0] umaskOut;
  logic        respValid;
  logic        respAllow;
  logic [1:0]  faultCause;
  logic        privFault;

  int checks = 0;
  int errors = 0;

  page_class_gate i_page_class_gate (.*);

  always #10 clk = ~clk;

  typedef struct packed {
    logic [1:0]  kind;    // 0 access, 1 authority write, 2 mask write
    logic        user;
    logic        isWr;
    logic [4:0]  key;
    logic [63:0] data;
    logic        expAllow;
    logic [1:0]  expCause;
    logic        expPriv;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{2'd1, 1'b0, 1'b0, 5'd0,  64'h4000_0000_0000_0000, 1'b0, 2'd0, 1'b0},
    '{2'd0, 1'b1, 1'b0, 5'd0,  64'h0,                   1'b0, 2'd1, 1'b0},
    '{2'd0, 1'b1, 1'b1, 5'd0,  64'h0,                   1'b1, 2'd0, 1'b0},
    '{2'd1, 1'b0, 1'b0, 5'd0,  64'h0000_0000_0000_0002, 1'b0, 2'd0, 1'b0},
    '{2'd0, 1'b0, 1'b1, 5'd31, 64'h0,                   1'b0, 2'd2, 1'b0},
    '{2'd0, 1'b0, 1'b0, 5'd31, 64'h0,                   1'b1, 2'd0, 1'b0},
    '{2'd0, 1'b1, 1'b0, 5'd0,  64'h0,                   1'b1, 2'd0, 1'b0},
    '{2'd2, 1'b1, 1'b0, 5'd0,  64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 2'd3, 1'b1},
    '{2'd2, 1'b0, 1'b0, 5'd0,  64'h0000_0000_0000_000F, 1'b0, 2'd0, 1'b0},
    '{2'd1, 1'b1, 1'b0, 5'd0,  64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 2'd0, 1'b0},
    '{2'd0, 1'b1, 1'b0, 5'd30, 64'h0,                   1'b0, 2'd1, 1'b0},
    '{2'd0, 1'b1, 1'b0, 5'd0,  64'h0,                   1'b1, 2'd0, 1'b0},
    '{2'd0, 1'b0, 1'b1, 5'd30, 64'h0,                   1'b0, 2'd2, 1'b0}
  };

  task automatic checkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic idle();
    accValid = 1'b0; regWrEn = 1'b0;
  endtask

  task automatic access(input logic [4:0] key, input logic wr, input logic usr);
    accValid = 1'b1; accKey = key; accWrite = wr; accUser = usr;
  endtask

  task automatic regWrite(input logic sel, input logic usr, input logic [63:0] d);
    regWrEn = 1'b1; regSel = sel; regWrUser = usr; regWrData = d;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL R9 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] mAuth;
    logic [63:0] mMask;
    mAuth = '0;
    mMask = '0;
    repeat (3) tick();
    rstN = 1'b1;
    // R1 reset state
    checkEq("R1 authOut", authOut, 64'h0);
    checkEq("R1 umaskOut", umaskOut, 64'h0);
    checkEq("R1 outputs", {62'h0, respValid, respAllow}, 64'h0);
    checkEq("R1 cause/priv", {61'h0, faultCause, privFault}, 64'h0);
    access(5'd5, 1'b1, 1'b1);
    tick();
    idle();
    checkEq("R1 allowed after reset", {62'h0, respValid, respAllow}, 64'h3);
    regWrite(1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    tick();
    idle();
    checkEq("R1 user write with zero mask", authOut, 64'h0);

    // table walk
    for (int i = 0; i < 13; i++) begin
      vec_t v;
      v = VECS[i];
      idle();
      if (v.kind == 2'd0) access(v.key, v.isWr, v.user);
      else regWrite(v.kind == 2'd2, v.user, v.data);
      if (v.kind == 2'd1) mAuth = v.user ? ((mAuth & ~mMask) | (v.data & mMask)) : v.data;
      if (v.kind == 2'd2 && !v.user) mMask = v.data;
      tick();
      idle();
      checkEq($sformatf("R9 respValid row %0d", i), {63'h0, respValid}, {63'h0, v.kind == 2'd0});
      checkEq($sformatf("R3 R4 allow row %0d", i), {63'h0, respAllow}, {63'h0, v.expAllow});
      checkEq($sformatf("R8 cause row %0d", i), {62'h0, faultCause}, {62'h0, v.expCause});
      checkEq($sformatf("R7 privFault row %0d", i), {63'h0, privFault}, {63'h0, v.expPriv});
      checkEq($sformatf("R10 R5 R6 authOut row %0d", i), authOut, mAuth);
      checkEq($sformatf("R10 R7 umaskOut row %0d", i), umaskOut, mMask);
    end

    // R2 bit position: class 17 write-disable is bit 29
    regWrite(1'b0, 1'b0, 64'h0000_0000_2000_0000);
    tick(); idle();
    access(5'd17, 1'b1, 1'b1); tick(); idle();
    checkEq("R2 class17 write refused", {62'h0, respAllow, faultCause}, {62'h0, 1'b0, 2'd2});
    access(5'd17, 1'b0, 1'b0); tick(); idle();
    checkEq("R2 class17 read allowed", {63'h0, respAllow}, 64'h1);
    access(5'd16, 1'b1, 1'b0); tick(); idle();
    checkEq("R2 class16 write allowed", {63'h0, respAllow}, 64'h1);
    access(5'd18, 1'b1, 1'b1); tick(); idle();
    checkEq("R2 class18 write allowed", {63'h0, respAllow}, 64'h1);

    // R9 same-cycle write uses old contents
    regWrite(1'b0, 1'b0, 64'h0);
    access(5'd17, 1'b1, 1'b0);
    tick(); idle();
    checkEq("R9 verdict from old contents", {63'h0, respAllow}, 64'h0);
    access(5'd17, 1'b1, 1'b0); tick(); idle();
    checkEq("R9 next access sees new contents", {63'h0, respAllow}, 64'h1);

    // R8 key fault outranks privilege fault in the same cycle
    regWrite(1'b0, 1'b0, 64'h4000_0000_0000_0000);
    tick(); idle();
    regWrite(1'b1, 1'b1, 64'h0);
    access(5'd0, 1'b0, 1'b1);
    tick(); idle();
    checkEq("R8 key cause wins", {62'h0, faultCause}, 64'h1);
    checkEq("R8 privFault still set", {63'h0, privFault}, 64'h1);
    checkEq("R7 mask unchanged", umaskOut, 64'h0000_0000_0000_000F);
    tick();
    checkEq("R7 privFault one cycle", {63'h0, privFault}, 64'h0);

    // R6 cleared mask blocks user writes
    regWrite(1'b1, 1'b0, 64'h0);
    tick(); idle();
    regWrite(1'b0, 1'b1, 64'h0);
    tick(); idle();
    checkEq("R6 user write blocked", authOut, 64'h4000_0000_0000_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule